// File: doc/BRIEF.md
# Bus-Driven Serial Configuration Loader

This block accepts a configuration bitstream from a 68000-style host, one bit per bus access. The host repeatedly writes to a single decoded strobe address. Each qualified access drives an active-low write strobe and takes data line 0 into a serial shift register. A plug-in adapter drives a presence sense input, and the strobe is gated by that input, so an image can only be loaded while the adapter is fitted.

The host sends each byte as eight accesses. Between accesses it shifts the byte right by one place, so bits arrive least significant first. A counter tracks the accepted bits. When the target device's bit count is reached, a sticky configured flag rises. Any trailing surplus bits in the image are then dropped. Each accepted bit is also presented as a one-cycle shift pulse with its data, so a downstream device can be fed. A window of the most recent bits is exposed.

Top module: `serial_cfg_loader`

## Requirements
- R1: `wrtN` is low exactly when `(busAddr & 24'hFE0200) == 24'h740200`, `asN` is low and `senseIn` is high. In the default decode, address bits 23..17 must equal 0111010 and bit 9 must be 1; all other bits are don't-care.
- R2: While `senseIn` is low, no access is accepted. `wrtN` stays high, and the window and configured flag do not change.
- R3: Each accepted access takes the value of `hostBit` into the shift register.
- R4: The window shifts right on each accepted bit, and the new bit enters at the top (bit SHIFT_W-1). After a byte has been sent least significant bit first in eight accesses, it sits in the top eight window bits.
- R5: One low period of `asN` on a matching address is accepted exactly once, however many clock cycles it lasts.
- R6: `configured` rises on the clock edge that accepts bit number CFG_BITS, counting from 1 after reset. It then stays high.
- R7: Once `configured` is high, further accesses shift nothing and produce no shift pulse. `wrtN` still follows R1.
- R8: Reset clears the window, the bit counter, the configured flag and the shift pulse.
- R9: For each accepted bit, `cfgShift` is high for exactly one cycle, with `cfgBit` equal to that bit. Both are registered on the accepting edge.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Host address bus |
| hostBit | input | 1 | Host data line 0 |
| asN | input | 1 | Host address strobe, active low |
| senseIn | input | 1 | Adapter presence sense, high when fitted |
| wrtN | output | 1 | Decoded write strobe, active low |
| cfgShift | output | 1 | One-cycle pulse per accepted bit |
| cfgBit | output | 1 | Bit carried with `cfgShift` |
| cfgWindow | output | SHIFT_W | Most recent accepted bits, newest at the top |
| configured | output | 1 | Expected bit count reached |

## Verification
The assertions assume that `asN`, `busAddr`, `hostBit` and `senseIn` are stable within a clock cycle. They also assume that `asN` goes high for at least one sampled cycle between accesses, so edge detection can see each new access. The bench drives every input on the falling clock edge. It holds the address, data and sense for the whole low period of `asN`, and it always leaves one idle cycle with `asN` high before the next access.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int unsigned DefAddrW = 24;
  localparam logic [23:0] DefMatchMask = 24'hFE0200;
  localparam logic [23:0] DefMatchValue = 24'h740200;
  localparam int unsigned DefCfgBits = 17878;
  localparam int unsigned DefShiftW = 32;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic shiftEn;
    logic dataBit;
    logic finalBit;
  } cfg_strobe_t;

endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import serial_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = DefAddrW,
  parameter logic [ADDR_W-1:0] MATCH_MASK = DefMatchMask,
  parameter logic [ADDR_W-1:0] MATCH_VALUE = DefMatchValue,
  parameter int unsigned CFG_BITS = DefCfgBits
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              hostBit,
  input  logic              asN,
  input  logic              senseIn,
  output logic              wrtN,
  output cfg_strobe_t       strobe,
  output logic              configured
);

  localparam int unsigned CNT_W = $clog2(CFG_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_BITS - 1);

  logic addrHit;
  logic accessLive;
  logic livePrev;
  logic newAccess;
  logic doneQ;
  logic [CNT_W-1:0] bitCnt;

  // Address decode and presence gating
  always_comb begin
    addrHit    = (busAddr & MATCH_MASK) == MATCH_VALUE;
    accessLive = addrHit & ~asN & senseIn;
    wrtN       = ~accessLive;
  end

  // Edge detection: one bit per access
  always_ff @(posedge clk) begin
    if (!rstN) livePrev <= 1'b0;
    else       livePrev <= accessLive;
  end

  always_comb begin
    newAccess       = accessLive & ~livePrev;
    strobe.shiftEn  = newAccess & ~doneQ;
    strobe.dataBit  = hostBit;
    strobe.finalBit = strobe.shiftEn & (bitCnt == LAST_IDX);
  end

  // Bit counter and done flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else if (strobe.shiftEn) begin
      bitCnt <= bitCnt + 1'b1;
      if (strobe.finalBit) doneQ <= 1'b1;
    end
  end

  assign configured = doneQ;

  a_r5_single_take: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);
  a_r2_no_take_without_sense: assert property (@(posedge clk) disable iff (!rstN)
    !senseIn |-> !strobe.shiftEn);
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    configured |=> configured);
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CFG_BITS));
  a_r6_done_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    configured |-> bitCnt == CNT_W'(CFG_BITS));
  a_r7_frozen_after_done: assert property (@(posedge clk) disable iff (!rstN)
    configured |-> !strobe.shiftEn);
  a_r5_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(bitCnt));

endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import serial_cfg_pkg::*;
#(
  parameter int unsigned SHIFT_W = DefShiftW
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfg_strobe_t        strobe,
  output logic               cfgShift,
  output logic               cfgBit,
  output logic [SHIFT_W-1:0] cfgWindow
);

  logic [SHIFT_W-1:0] winNext;

  generate
    if (SHIFT_W > 1) begin : g_wide
      assign winNext = {strobe.dataBit, cfgWindow[SHIFT_W-1:1]};
    end else begin : g_single
      assign winNext = strobe.dataBit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWindow <= '0;
      cfgShift  <= 1'b0;
      cfgBit    <= 1'b0;
    end else begin
      cfgShift <= strobe.shiftEn;
      if (strobe.shiftEn) begin
        cfgWindow <= winNext;
        cfgBit    <= strobe.dataBit;
      end
    end
  end

  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cfgShift |=> !cfgShift);
  a_r4_new_bit_at_top: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> cfgWindow[SHIFT_W-1] == $past(strobe.dataBit));
  a_r7_window_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(cfgWindow));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = DefAddrW,
  parameter logic [ADDR_W-1:0] MATCH_MASK = DefMatchMask,
  parameter logic [ADDR_W-1:0] MATCH_VALUE = DefMatchValue,
  parameter int unsigned CFG_BITS = DefCfgBits,
  parameter int unsigned SHIFT_W = DefShiftW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               hostBit,
  input  logic               asN,
  input  logic               senseIn,
  output logic               wrtN,
  output logic               cfgShift,
  output logic               cfgBit,
  output logic [SHIFT_W-1:0] cfgWindow,
  output logic               configured
);

  cfg_strobe_t strobe;

  cfg_ctrl #(
    .ADDR_W(ADDR_W),
    .MATCH_MASK(MATCH_MASK),
    .MATCH_VALUE(MATCH_VALUE),
    .CFG_BITS(CFG_BITS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .hostBit(hostBit),
    .asN(asN),
    .senseIn(senseIn),
    .wrtN(wrtN),
    .strobe(strobe),
    .configured(configured)
  );

  cfg_datapath #(
    .SHIFT_W(SHIFT_W)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .cfgShift(cfgShift),
    .cfgBit(cfgBit),
    .cfgWindow(cfgWindow)
  );

endmodule

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;

  localparam int unsigned AW = 24;
  localparam int unsigned NBITS = 40;
  localparam int unsigned SW = 16;
  localparam logic [AW-1:0] MASK = 24'hFE0200;
  localparam logic [AW-1:0] VAL = 24'h740200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic hostBit = 1'b0;
  logic asN = 1'b1;
  logic senseIn = 1'b0;
  logic wrtN, cfgShift, cfgBit, configured;
  logic [SW-1:0] cfgWindow;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [SW-1:0] expWin;
  int expCnt;
  bit expDone;

  always #2 clk = ~clk;

  serial_cfg_loader #(.ADDR_W(AW), .MATCH_MASK(MASK), .MATCH_VALUE(VAL),
                      .CFG_BITS(NBITS), .SHIFT_W(SW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .hostBit(hostBit), .asN(asN),
    .senseIn(senseIn), .wrtN(wrtN), .cfgShift(cfgShift), .cfgBit(cfgBit),
    .cfgWindow(cfgWindow), .configured(configured));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; asN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expWin = '0; expCnt = 0; expDone = 0;
  endtask

  // One host access lasting 'hold' cycles, followed by one idle cycle
  task automatic doWrite(input logic [AW-1:0] a, input logic d, input logic s, input int hold);
    bit hit, take;
    hit = ((a & MASK) == VAL) && s;
    take = hit && !expDone;
    @(negedge clk);
    busAddr = a; hostBit = d; senseIn = s; asN = 1'b0;
    #1;
    check(s ? "R1 strobe decode" : "R2 strobe gated", {31'b0, wrtN}, {31'b0, !hit});
    @(negedge clk);
    check(expDone ? "R7 no pulse after done" : "R9 shift pulse", {31'b0, cfgShift}, {31'b0, take});
    if (take) check("R9 pulse bit", {31'b0, cfgBit}, {31'b0, d});
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      check("R5 single take per access", {31'b0, cfgShift}, 32'b0);
    end
    asN = 1'b1;
    if (take) begin
      expWin = {d, expWin[SW-1:1]};
      expCnt++;
      if (expCnt == NBITS) expDone = 1;
    end
    #1;
    check("R3 R4 window", {16'b0, cfgWindow}, {16'b0, expWin});
    check("R6 configured", {31'b0, configured}, {31'b0, expDone});
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic [7:0] v;
    v = b;
    for (int k = 0; k < 8; k++) begin
      doWrite(VAL, v[0], 1'b1, 1);
      v = v >> 1;
    end
  endtask

  initial begin
    expWin = '0; expCnt = 0; expDone = 0;
    doReset();
    check("R8 reset window", {16'b0, cfgWindow}, 32'b0);
    check("R8 reset configured", {31'b0, configured}, 32'b0);
    check("R8 reset pulse", {31'b0, cfgShift}, 32'b0);

    // R1: flip each address bit in turn; mask bits must break the match
    for (int i = 0; i < AW; i++) doWrite(VAL ^ (24'h1 << i), i[0], 1'b1, 1);
    // R1: idle strobe leaves wrtN high
    @(negedge clk); busAddr = VAL; senseIn = 1'b1; asN = 1'b1; #1;
    check("R1 idle asN", {31'b0, wrtN}, 32'b1);

    // R8: reset after bits were taken
    doReset();
    check("R8 window cleared", {16'b0, cfgWindow}, 32'b0);

    // R2: sense low blocks everything
    doWrite(VAL, 1'b1, 1'b0, 1);
    doWrite(VAL, 1'b1, 1'b0, 3);
    doWrite(24'h7403FF, 1'b1, 1'b0, 1);

    // R3: data line values
    doWrite(VAL, 1'b1, 1'b1, 1);
    doWrite(24'h75FDFF & 24'hFFFFFF, 1'b0, 1'b1, 1);
    // R5: long access counts once
    doWrite(VAL, 1'b1, 1'b1, 6);

    // R4: two bytes least significant bit first
    sendByte(8'hA5);
    check("R4 byte at top", {24'b0, cfgWindow[SW-1 -: 8]}, 32'hA5);
    sendByte(8'h3C);
    check("R4 two bytes", {16'b0, cfgWindow}, 32'h3CA5);

    // R6: fill up to the limit, then surplus bits (R7)
    for (int j = 0; expCnt < NBITS - 1; j++) doWrite(VAL, j[1] ^ j[0], 1'b1, 1);
    check("R6 not yet configured", {31'b0, configured}, 32'b0);
    doWrite(VAL, 1'b1, 1'b1, 1);
    check("R6 configured at limit", {31'b0, configured}, 32'b1);
    for (int j = 0; j < 5; j++) doWrite(VAL, ~expWin[SW-1], 1'b1, 2);
    check("R7 window frozen", {16'b0, cfgWindow}, {16'b0, expWin});

    doReset();
    check("R8 configured cleared", {31'b0, configured}, 32'b0);
    check("R8 window cleared again", {16'b0, cfgWindow}, 32'b0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule